// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 128 interrupt request lines, turns each into a pending bit according to a per-line trigger type, and presents the most urgent enabled request to a processor on a single active-low request output. Software reaches every per-line setting (priority, trigger type, vector word, enable, pending clear and set) through one window. It first writes a line number into a select register, and all per-line registers then act on that line.

Servicing works by acknowledgement. A read of the acknowledge register returns the vector word of the winning line, records that line as current, and pushes its priority onto a nesting stack of up to eight entries. While the stack is not empty, only a strictly more urgent request can drive the output low again. A write to the end-of-service register pops one stack entry. If the acknowledge register is read while no request is eligible, it returns a programmable spurious vector. A status register exposes the request output, and four pending words expose the raw pending state of all lines.

Top module: `vpic_top`

## Requirements
- R1: The select register (offset 0x00) keeps written bits [6:0] as the line number and reads them back. The mode register (0x04) holds the selected line's priority in bits [2:0] (7 most urgent) and its trigger type in bits [6:5]. The vector register (0x08) holds the selected line's 32-bit vector word. All three read back the stored values of the selected line.
- R2: A write to enable (0x40), disable (0x44), pending clear (0x48) or pending set (0x4C) acts on the selected line only when write data bit 0 is 1; otherwise it changes nothing. Offset 0x30 reads the selected line's enable bit in bit 0.
- R3: Trigger type 0 is low level, 1 is falling edge, 2 is high level and 3 is rising edge. A level line's pending bit equals its input condition in the same cycle, and pending clear and set writes have no effect on it.
- R4: An edge line's pending bit is set one clock after its edge, seen by comparing the input with its value on the previous clock. It then stays set until a clear write or an acknowledge of that line. An edge in the same cycle as a clear wins. Rewriting the mode of a line drops its latched edge.
- R5: Offsets 0x20, 0x24, 0x28 and 0x2C read the pending bits of lines 0-31, 32-63, 64-95 and 96-127, with line 32k+j in bit j of word k.
- R6: The request output is low exactly when some enabled pending line exists and either the nesting stack is empty or that line's priority is strictly above the stack top. The winner has the highest priority, and among equals the lowest line number.
- R7: Reading the acknowledge register (0x10) while the request output is low returns the winner's vector word, pushes its priority, clears its pending bit if it is edge-triggered, and makes offset 0x18 read the winner's line number.
- R8: Reading 0x10 while the request output is high returns the spurious vector stored at 0x3C, leaves the stack unchanged, and makes 0x18 read 0.
- R9: Each write to 0x38 pops one stack entry and does nothing on an empty stack, so eight such writes always empty it. Offset 0x34 reads 1 in bit 0 (no fast request) and the request output in bit 1.
- R10: After reset all lines are disabled, with priority 0, trigger type 0 and vector 0. Select, spurious vector and current line are 0, the stack is empty and the request output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| src_in | input | 128 | Interrupt request lines, already synchronous to clk |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a full nesting stack. Filling it takes eight acknowledges in strictly rising priority order, because an equal or lower request never drives the output low while a level is in service. The bench disables every line, holds all inputs active, and enables one line per priority level from 0 to 7, acknowledging each in turn. It then issues a spurious acknowledge at full depth and unwinds with nine end-of-service writes. A bench-side stack model predicts the output after every step. Random sparse input patterns under several enable masks exercise ties and the lowest-index rule.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  typedef enum logic [1:0] {
    TRG_LOW  = 2'd0,
    TRG_FALL = 2'd1,
    TRG_HIGH = 2'd2,
    TRG_RISE = 2'd3
  } trig_e;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_SEL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_VEC   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TAKE  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CUR   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_PEND0 = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ENRD  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_CORE  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_EOI   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_SPUR  = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_ENA   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_DIS   = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h4C;

  // true for the two edge-sensitive trigger encodings
  function automatic logic trig_is_edge(input trig_e t);
    return (t == TRG_FALL) || (t == TRG_RISE);
  endfunction

  // input condition of a level-sensitive line
  function automatic logic level_active(input trig_e t, input logic s);
    return (t == TRG_HIGH) ? s : !s;
  endfunction

  // edge event for the edge-sensitive encodings
  function automatic logic edge_seen(input trig_e t, input logic now_v, input logic prev_v);
    return (t == TRG_RISE) ? (now_v && !prev_v) : (!now_v && prev_v);
  endfunction

endpackage

// File: rtl/vpic_src_bank.sv
module vpic_src_bank import vpic_pkg::*; #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0]               src_in,
  input  logic [IDX_W-1:0]                 sel_idx,
  input  logic                             wr_mode,
  input  logic [PRIO_W-1:0]                mode_prio,
  input  logic [1:0]                       mode_trig,
  input  logic                             wr_vec,
  input  logic [VEC_W-1:0]                 vec_data,
  input  logic                             cmd_en,
  input  logic                             cmd_dis,
  input  logic                             cmd_clr,
  input  logic                             cmd_set,
  input  logic                             take,
  input  logic [IDX_W-1:0]                 take_idx,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o,
  output logic [NUM_SRC-1:0][1:0]          trig_o,
  output logic [NUM_SRC-1:0][VEC_W-1:0]    vec_o,
  output logic [NUM_SRC-1:0]               en_o,
  output logic [NUM_SRC-1:0]               pend_o
);

  logic [NUM_SRC-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_in;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    logic              sel_hit;
    logic              take_hit;
    logic              is_edge;
    logic              edge_ev;
    logic [PRIO_W-1:0] prio_q;
    logic [1:0]        trig_q;
    logic [VEC_W-1:0]  vec_q;
    logic              en_q;
    logic              latch_q;

    assign sel_hit  = (sel_idx == IDX_W'(i));
    assign take_hit = take && (take_idx == IDX_W'(i));
    assign is_edge  = trig_is_edge(trig_e'(trig_q));
    assign edge_ev  = is_edge && edge_seen(trig_e'(trig_q), src_in[i], src_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q  <= '0;
        trig_q  <= TRG_LOW;
        vec_q   <= '0;
        en_q    <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        if (sel_hit && wr_mode) begin
          prio_q <= mode_prio;
          trig_q <= mode_trig;
        end
        if (sel_hit && wr_vec) vec_q <= vec_data;
        if (sel_hit && cmd_en)       en_q <= 1'b1;
        else if (sel_hit && cmd_dis) en_q <= 1'b0;
        // mode rewrite drops a stale edge; a fresh edge beats clear/ack
        if (sel_hit && wr_mode)                          latch_q <= 1'b0;
        else if (edge_ev || (sel_hit && cmd_set && is_edge)) latch_q <= 1'b1;
        else if ((sel_hit && cmd_clr) || take_hit)       latch_q <= 1'b0;
      end
    end

    assign prio_o[i] = prio_q;
    assign trig_o[i] = trig_q;
    assign vec_o[i]  = vec_q;
    assign en_o[i]   = en_q;
    assign pend_o[i] = is_edge ? latch_q : level_active(trig_e'(trig_q), src_in[i]);
  end

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 3,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             cand,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           any_o,
  output logic [PRIO_W-1:0]              best_o,
  output logic [IDX_W-1:0]               win_o
);

  localparam int LEVELS = 1 << PRIO_W;

  logic [LEVELS-1:0] lvl_hit;

  // highest set bit of the level-occupancy vector
  function automatic logic [PRIO_W-1:0] top_level(input logic [LEVELS-1:0] v);
    logic [PRIO_W-1:0] r;
    r = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (v[l]) r = PRIO_W'(l);
    end
    return r;
  endfunction

  always_comb begin
    lvl_hit = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i]) lvl_hit[prio_i[i]] = 1'b1;
    end
  end

  assign any_o  = |cand;
  assign best_o = top_level(lvl_hit);

  // scan downward so the lowest index at the best level is kept
  always_comb begin
    win_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (prio_i[i] == best_o)) win_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/vpic_nest.sv
module vpic_nest #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_lvl,
  output logic [CNT_W-1:0]  depth_o,
  output logic [PRIO_W-1:0] top_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] lv_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              full;
  logic              empty;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) lv_q[k] <= '0;
    end else if (push && !full) begin
      lv_q[cnt_q[PTR_W-1:0]] <= push_lvl;
      cnt_q                  <= cnt_q + 1'b1;
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign depth_o = cnt_q;
  assign top_o   = empty ? '0 : lv_q[PTR_W'(cnt_q - 1'b1)];

endmodule

// File: rtl/vpic_top.sv
module vpic_top import vpic_pkg::*; #(
  parameter int NUM_SRC    = 128,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 32,
  parameter int NEST_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_n
);

  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int CNT_W      = $clog2(NEST_DEPTH + 1);
  localparam int PEND_WORDS = NUM_SRC / 32;
  localparam int PW_W       = (PEND_WORDS > 1) ? $clog2(PEND_WORDS) : 1;

  // bus decode
  logic wr_ev, rd_ev;
  logic wr_mode, wr_vec, cmd_en, cmd_dis, cmd_clr, cmd_set;
  logic take_ev, spur_ev, eoi_ev;

  // state
  logic [IDX_W-1:0] sel_q;
  logic [VEC_W-1:0] spur_q;
  logic [IDX_W-1:0] cur_q;

  // per-line views
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all;
  logic [NUM_SRC-1:0][1:0]        trig_all;
  logic [NUM_SRC-1:0][VEC_W-1:0]  vec_all;
  logic [NUM_SRC-1:0]             en_all;
  logic [NUM_SRC-1:0]             pend_all;
  logic [PEND_WORDS-1:0][31:0]    pend_words;

  // arbitration and nesting
  logic              arb_any;
  logic [PRIO_W-1:0] arb_best;
  logic [IDX_W-1:0]  arb_win;
  logic [CNT_W-1:0]  nest_depth;
  logic [PRIO_W-1:0] nest_top;
  logic              irq_req;

  // eligibility: something pending, and above the level in service
  function automatic logic may_interrupt(input logic any, input logic [PRIO_W-1:0] best,
                                         input logic nested, input logic [PRIO_W-1:0] top);
    return any && (!nested || (best > top));
  endfunction

  assign wr_ev   = bus_sel &&  bus_wr;
  assign rd_ev   = bus_sel && !bus_wr;
  assign wr_mode = wr_ev && (bus_addr == OFS_MODE);
  assign wr_vec  = wr_ev && (bus_addr == OFS_VEC);
  assign cmd_en  = wr_ev && (bus_addr == OFS_ENA) && bus_wdata[0];
  assign cmd_dis = wr_ev && (bus_addr == OFS_DIS) && bus_wdata[0];
  assign cmd_clr = wr_ev && (bus_addr == OFS_CLR) && bus_wdata[0];
  assign cmd_set = wr_ev && (bus_addr == OFS_SET) && bus_wdata[0];
  assign eoi_ev  = wr_ev && (bus_addr == OFS_EOI);

  assign irq_req = may_interrupt(arb_any, arb_best, nest_depth != '0, nest_top);
  assign irq_n   = !irq_req;
  assign take_ev = rd_ev && (bus_addr == OFS_TAKE) &&  irq_req;
  assign spur_ev = rd_ev && (bus_addr == OFS_TAKE) && !irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      spur_q <= '0;
      cur_q  <= '0;
    end else begin
      if (wr_ev && (bus_addr == OFS_SEL))  sel_q  <= bus_wdata[IDX_W-1:0];
      if (wr_ev && (bus_addr == OFS_SPUR)) spur_q <= bus_wdata[VEC_W-1:0];
      if (take_ev)      cur_q <= arb_win;
      else if (spur_ev) cur_q <= '0;
    end
  end

  vpic_src_bank #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .VEC_W   (VEC_W),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .sel_idx   (sel_q),
    .wr_mode   (wr_mode),
    .mode_prio (bus_wdata[PRIO_W-1:0]),
    .mode_trig (bus_wdata[6:5]),
    .wr_vec    (wr_vec),
    .vec_data  (bus_wdata[VEC_W-1:0]),
    .cmd_en    (cmd_en),
    .cmd_dis   (cmd_dis),
    .cmd_clr   (cmd_clr),
    .cmd_set   (cmd_set),
    .take      (take_ev),
    .take_idx  (arb_win),
    .prio_o    (prio_all),
    .trig_o    (trig_all),
    .vec_o     (vec_all),
    .en_o      (en_all),
    .pend_o    (pend_all)
  );

  vpic_arbiter #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
  ) u_arb (
    .cand   (pend_all & en_all),
    .prio_i (prio_all),
    .any_o  (arb_any),
    .best_o (arb_best),
    .win_o  (arb_win)
  );

  vpic_nest #(
    .DEPTH  (NEST_DEPTH),
    .PRIO_W (PRIO_W),
    .CNT_W  (CNT_W)
  ) u_nest (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take_ev),
    .pop      (eoi_ev),
    .push_lvl (arb_best),
    .depth_o  (nest_depth),
    .top_o    (nest_top)
  );

  // read path
  logic [7:0]      pend_off;
  logic            in_pend;
  logic [PW_W-1:0] pend_idx;

  assign pend_words = pend_all;
  assign pend_off   = bus_addr - OFS_PEND0;
  assign in_pend    = (pend_off < 8'(4 * PEND_WORDS));
  assign pend_idx   = pend_off[PW_W+1:2];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_SEL:  bus_rdata[IDX_W-1:0] = sel_q;
      OFS_MODE: begin
        bus_rdata[PRIO_W-1:0] = prio_all[sel_q];
        bus_rdata[6:5]        = trig_all[sel_q];
      end
      OFS_VEC:  bus_rdata[VEC_W-1:0] = vec_all[sel_q];
      OFS_TAKE: bus_rdata[VEC_W-1:0] = irq_req ? vec_all[arb_win] : spur_q;
      OFS_CUR:  bus_rdata[IDX_W-1:0] = cur_q;
      OFS_ENRD: bus_rdata[0]         = en_all[sel_q];
      OFS_CORE: bus_rdata[1:0]       = {irq_n, 1'b1};
      OFS_SPUR: bus_rdata[VEC_W-1:0] = spur_q;
      default:  if (in_pend) bus_rdata = pend_words[pend_idx];
    endcase
  end

endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
  parameter int NEST_DEPTH = 8,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 32,
  parameter int CNT_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_n,
  input logic              take_ev,
  input logic              spur_ev,
  input logic              eoi_ev,
  input logic              arb_any,
  input logic [PRIO_W-1:0] arb_best,
  input logic [PRIO_W-1:0] nest_top,
  input logic [CNT_W-1:0]  nest_depth,
  input logic [31:0]       bus_rdata,
  input logic [VEC_W-1:0]  spur_q
);

  // R9: the stack never holds more than its depth
  p_depth_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= CNT_W'(NEST_DEPTH));

  // R7: an acknowledge pushes exactly one level
  p_take_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> nest_depth == $past(nest_depth) + 1'b1);

  // R9: end-of-service on a non-empty stack pops one level
  p_eoi_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ev && nest_depth != '0) |=> nest_depth == $past(nest_depth) - 1'b1);

  // R8: a spurious acknowledge leaves the stack alone
  p_spur_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spur_ev |=> nest_depth == $past(nest_depth));

  // R8: a spurious acknowledge returns the programmed spurious word
  p_spur_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spur_ev |-> bus_rdata[VEC_W-1:0] == spur_q);

  // R6: while nested, a request needs a strictly higher level
  p_nest_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_depth != '0 && !irq_n) |-> arb_best > nest_top);

  // R6: no request without an enabled pending line
  p_req_needs_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> arb_any);

endmodule

bind vpic_top vpic_chk #(
  .NEST_DEPTH (NEST_DEPTH),
  .PRIO_W     (PRIO_W),
  .VEC_W      (VEC_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_n      (irq_n),
  .take_ev    (take_ev),
  .spur_ev    (spur_ev),
  .eoi_ev     (eoi_ev),
  .arb_any    (arb_any),
  .arb_best   (arb_best),
  .nest_top   (nest_top),
  .nest_depth (nest_depth),
  .bus_rdata  (bus_rdata),
  .spur_q     (spur_q)
);

// File: tb/vpic_top_tb.sv
module vpic_top_tb;

  localparam int N = 128;
  localparam logic [31:0] SPUR_WORD = 32'h5A5A_0001;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = 8'h00;
  logic [31:0]  bus_wdata = 32'h0;
  logic [31:0]  bus_rdata;
  logic [N-1:0] src_in = '1;
  logic         irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  vpic_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_in    (src_in),
    .irq_n     (irq_n)
  );

  // bench-side model
  int       sh_prio [N];
  int       sh_trig [N];
  logic [31:0] sh_vec [N];
  bit       sh_en [N];
  bit       sh_ep [N];
  int       sk [8];
  int       sd = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] next_rand();
    seed = xs(seed);
    return seed;
  endfunction

  function automatic bit exp_pend(input int i);
    case (sh_trig[i])
      0:       return !src_in[i];
      2:       return src_in[i];
      default: return sh_ep[i];
    endcase
  endfunction

  task automatic find_win(output bit f, output int best, output int w);
    f = 0; best = 0; w = 0;
    for (int i = 0; i < N; i++) begin
      if (sh_en[i] && exp_pend(i) && (!f || sh_prio[i] > best)) begin
        f = 1; best = sh_prio[i]; w = i;
      end
    end
  endtask

  task automatic exp_irq(output bit r);
    bit f; int b; int w;
    find_win(f, b, w);
    r = f && (sd == 0 || b > sk[sd-1]);
  endtask

  task automatic check_irq(input string tag);
    bit r;
    exp_irq(r);
    check(tag, {31'd0, irq_n}, {31'd0, !r});
  endtask

  task automatic do_take(input string tag);
    bit f; int b; int w; bit fire;
    logic [31:0] d;
    find_win(f, b, w);
    fire = f && (sd == 0 || b > sk[sd-1]);
    bus_read(8'h10, d);
    if (fire) begin
      check({tag, " R7 vector"}, d, sh_vec[w]);
      sk[sd] = b; sd++;
      if (sh_trig[w] == 1 || sh_trig[w] == 3) sh_ep[w] = 0;
    end else begin
      check({tag, " R8 spurious vector"}, d, SPUR_WORD);
    end
    bus_read(8'h18, d);
    check({tag, " R7/R8 current id"}, d, fire ? 32'(w) : 32'd0);
  endtask

  task automatic do_eoi();
    bus_write(8'h38, 32'd0);
    if (sd > 0) sd--;
  endtask

  task automatic set_mode(input int i, input int p, input int t);
    bus_write(8'h00, 32'(i));
    bus_write(8'h04, 32'(p) | (32'(t) << 5));
    sh_prio[i] = p; sh_trig[i] = t; sh_ep[i] = 0;
  endtask

  task automatic set_en(input int i, input bit e);
    bus_write(8'h00, 32'(i));
    bus_write(e ? 8'h44 - 8'h04 : 8'h44, 32'd1);
    sh_en[i] = e;
  endtask

  task automatic check_pend_words(input string tag);
    logic [31:0] d, e;
    for (int k = 0; k < 4; k++) begin
      bus_read(8'(8'h20 + 4 * k), d);
      e = 32'd0;
      for (int j = 0; j < 32; j++) e[j] = exp_pend(32 * k + j);
      check(tag, d, e);
    end
  endtask

  function automatic logic [N-1:0] rand_sparse();
    logic [N-1:0] v;
    for (int k = 0; k < 4; k++) v[32*k +: 32] = next_rand() & next_rand() & next_rand();
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin
      sh_prio[i] = 0; sh_trig[i] = 0; sh_vec[i] = 0; sh_en[i] = 0; sh_ep[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    check("R10 irq_n after reset", {31'd0, irq_n}, 32'd1);
    bus_read(8'h04, d); check("R10 mode of line 0", d, 32'd0);
    bus_read(8'h08, d); check("R10 vector of line 0", d, 32'd0);
    bus_read(8'h30, d); check("R10 enable of line 0", d, 32'd0);
    bus_read(8'h00, d); check("R10 select", d, 32'd0);
    bus_read(8'h34, d); check("R10 R9 core status", d, 32'd3);
    check_pend_words("R10 R5 pending, inputs high, low-level type");
    bus_read(8'h10, d); check("R10 R8 spurious word at reset", d, 32'd0);
    bus_read(8'h18, d); check("R10 R8 current id", d, 32'd0);

    // R1: program and read back every line
    bus_write(8'h3C, SPUR_WORD);
    for (int i = 0; i < N; i++) begin
      int p;
      p = (i * 5 + 3) % 8;
      bus_write(8'h00, 32'h80 | 32'(i));
      bus_read(8'h00, d); check("R1 select keeps bits 6:0", d, 32'(i));
      bus_write(8'h04, 32'(p) | (32'd2 << 5));
      bus_write(8'h08, 32'hC0DE_0000 + 32'(i * 7));
      sh_prio[i] = p; sh_trig[i] = 2; sh_vec[i] = 32'hC0DE_0000 + 32'(i * 7);
      bus_read(8'h04, d); check("R1 mode readback", d, 32'(p) | 32'h40);
      bus_read(8'h08, d); check("R1 vector readback", d, sh_vec[i]);
    end

    // R3/R5: level pending follows inputs
    src_in = rand_sparse() | rand_sparse();
    check_pend_words("R3 R5 high-level pattern A");
    src_in = ~src_in;
    check_pend_words("R3 R5 high-level pattern B");
    set_mode(5, sh_prio[5], 0);
    check_pend_words("R3 low-level line 5");
    src_in[5] = ~src_in[5];
    check_pend_words("R3 low-level line 5 toggled");
    set_mode(5, sh_prio[5], 2);
    src_in[7] = 1'b0;
    bus_write(8'h00, 32'd7); bus_write(8'h4C, 32'd1);
    bus_read(8'h20, d); check("R3 set ignored on level line", {31'd0, d[7]}, 32'd0);
    src_in[7] = 1'b1;
    bus_write(8'h48, 32'd1);
    bus_read(8'h20, d); check("R3 clear ignored on level line", {31'd0, d[7]}, 32'd1);

    // R2: enable/disable commands gated by data bit 0
    bus_write(8'h00, 32'd20);
    bus_write(8'h40, 32'd0); bus_read(8'h30, d); check("R2 enable with bit0=0", d, 32'd0);
    bus_write(8'h40, 32'd1); bus_read(8'h30, d); check("R2 enable", d, 32'd1);
    bus_write(8'h44, 32'd2); bus_read(8'h30, d); check("R2 disable with bit0=0", d, 32'd1);
    bus_write(8'h44, 32'd1); bus_read(8'h30, d); check("R2 disable", d, 32'd0);

    // R4: edge latching
    src_in[10] = 1'b0; src_in[11] = 1'b1;
    set_mode(10, sh_prio[10], 3);
    set_mode(11, sh_prio[11], 1);
    bus_read(8'h20, d); check("R4 rising line idle", {31'd0, d[10]}, 32'd0);
    src_in[10] = 1'b1;
    bus_read(8'h20, d); check("R4 rising edge latched", {31'd0, d[10]}, 32'd1);
    src_in[10] = 1'b0;
    bus_read(8'h20, d); check("R4 latch holds after input drops", {31'd0, d[10]}, 32'd1);
    bus_write(8'h00, 32'd10);
    bus_write(8'h48, 32'd0);
    bus_read(8'h20, d); check("R2 clear with bit0=0", {31'd0, d[10]}, 32'd1);
    bus_write(8'h48, 32'd1);
    bus_read(8'h20, d); check("R4 clear command", {31'd0, d[10]}, 32'd0);
    bus_write(8'h4C, 32'd1);
    bus_read(8'h20, d); check("R4 set command", {31'd0, d[10]}, 32'd1);
    sh_ep[10] = 1;
    src_in[11] = 1'b0;
    bus_read(8'h20, d); check("R4 falling edge latched", {31'd0, d[11]}, 32'd1);
    bus_write(8'h00, 32'd11); bus_write(8'h48, 32'd1);
    src_in[11] = 1'b1;
    bus_read(8'h20, d); check("R4 falling line ignores rise", {31'd0, d[11]}, 32'd0);

    // R7: acknowledge clears the edge latch
    set_en(10, 1);
    check_irq("R6 edge line requests");
    do_take("edge line");
    bus_read(8'h20, d); check("R7 edge latch cleared by acknowledge", {31'd0, d[10]}, 32'd0);
    check_irq("R6 after acknowledge");
    do_eoi();
    check_irq("R9 after end of service, latch gone");
    set_en(10, 0);
    set_mode(10, sh_prio[10], 2);
    set_mode(11, sh_prio[11], 2);

    // R6/R7: arbitration under several enable masks and input patterns
    for (int e = 0; e < 4; e++) begin
      for (int i = 0; i < N; i++) begin
        bit want;
        want = (e == 3) ? 1'b1 : next_rand()[4];
        set_en(i, want);
      end
      for (int k = 0; k < 10; k++) begin
        src_in = (k == 0) ? '0 : rand_sparse();
        @(negedge clk);
        check_irq("R6 request level");
        do_take("R6 arbitration");
        check_irq("R6 after acknowledge");
        do_eoi();
        check_irq("R9 after end of service");
      end
    end

    // R6/R7/R8/R9: fill the stack in rising order
    for (int i = 0; i < N; i++) set_en(i, 0);
    src_in = '1;
    @(negedge clk);
    check_irq("R6 nothing enabled");
    for (int p = 0; p < 8; p++) begin
      int j;
      j = 0;
      for (int i = N - 1; i >= 0; i--) if (sh_prio[i] == p) j = i;
      set_en(j, 1);
      check_irq("R6 higher level requests while nested");
      do_take("R7 nest push");
      check_irq("R6 equal level blocked");
    end
    check("R9 stack full", 32'(sd), 32'd8);
    do_take("R8 spurious at full depth");
    check_irq("R8 state after spurious");
    for (int k = 0; k < 9; k++) begin
      do_eoi();
      check_irq("R9 unwind");
      bus_read(8'h34, d);
      check("R9 core status tracks request", d, {30'd0, irq_n, 1'b1});
    end
    do_take("R9 stack empty again");
    do_eoi();
    check_irq("R9 final");

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule